// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block counts activity inside a processor core. It holds one free-running cycle counter and two event counters, all 32 bits wide. Each event counter watches one line of a vector of single-cycle event pulses from the core. An 8-bit code in the control word picks that line. When a counter wraps past its maximum value it raises an overflow flag. Software can turn each flag into an interrupt request.

Software reaches the block through a small register port with a 2-bit index. Index 0 is the packed control word, index 1 the cycle counter, index 2 event counter 0 and index 3 event counter 1. A read returns the current value in the same cycle. A write takes effect at the next clock edge.

Counting is gated by a four-state mode machine. The states are STOP_FULL, STOP_DIV, RUN_FULL and RUN_DIV. A write to the control word moves the machine to the state named by the written enable and divide bits; with no such write the machine keeps its state. In RUN_DIV a 6-bit prescaler paces the cycle counter. Leaving RUN_DIV, or resetting the cycle counter, clears the prescaler.

Top module: `perf_monitor`

## Requirements
- R1: After reset, the control word reads 0x0FFFF000: both event codes are 0xFF and every other field is 0. All three counters read 0 and `irq` is low.
- R2: While control bit 0 (enable) is 0, no counter advances, whatever pulses arrive on `evt_in`.
- R3: With bit 0 set and bit 3 (divide) clear, the cycle counter advances by one on every clock. With both set, it advances once per 64 clocks. After the divided mode is entered, or after the cycle counter is reset, the first advance comes on the 64th clock.
- R4: Event counter 0 advances in each enabled cycle in which `evt_in[code0]` is high, where code0 is control bits 19:12. Event counter 1 works the same way with code1, held in bits 27:20. A code of 0xFF, or any code of 23 or more, never counts.
- R5: A write of 1 to control bit 1 zeroes both event counters. A write of 1 to bit 2 zeroes the cycle counter and its prescaler. Both bits always read back as 0. A reset wins over an increment in the same cycle.
- R6: Register index 0 selects the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A read returns the current value. A counter write loads the written value at the next edge and wins over an increment in that cycle.
- R7: When a counter wraps from 0xFFFFFFFF to 0, its overflow flag is set. The flags sit at control bit 8 (event counter 0), bit 9 (event counter 1) and bit 10 (cycle counter).
- R8: Writing 1 to a flag bit clears that flag, and writing 0 leaves it alone. When a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when some flag is set and its enable is set. The enables sit at bit 4 (event counter 0), bit 5 (event counter 1) and bit 6 (cycle counter).
- R10: Control bits 31:28, 7 and 11 ignore writes and always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register index: 0 control, 1 cycle counter, 2 event counter 0, 3 event counter 1 |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current value of the selected register |
| evt_in | input | 23 | Single-cycle event pulses from the core |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two pairs of functions can land on the same edge.

- A counter wrap can meet a write that clears the flags. The bench loads event counter 0 with 0xFFFFFFFF, then drives the selected pulse in the same cycle as a control write with bit 8 set. It expects the flag, and `irq`, to stay set.
- A reset or load can meet an increment. The bench issues the reset-bit writes and the counter writes while pulses and cycle ticks are live. It expects the written value or zero, never the incremented one.

A behavioural reference model runs alongside and is compared against the read port and `irq` on every clock.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    // control word field positions (decoded by software)
    localparam int CTL_EN      = 0;
    localparam int CTL_EVRST   = 1;
    localparam int CTL_CYRST   = 2;
    localparam int CTL_DIV     = 3;
    localparam int CTL_IE_EV0  = 4;
    localparam int CTL_IE_EV1  = 5;
    localparam int CTL_IE_CYC  = 6;
    localparam int CTL_OF_EV0  = 8;
    localparam int CTL_OF_EV1  = 9;
    localparam int CTL_OF_CYC  = 10;
    localparam int CTL_SEL0_LO = 12;
    localparam int CTL_SEL1_LO = 20;
    localparam int SEL_W       = 8;
    localparam int REG_W       = 32;

    localparam logic [SEL_W-1:0] CODE_NONE = 8'hFF;

    // counter slots: 0 cycle, 1 event0, 2 event1
    localparam int N_EVC = 2;
    localparam int N_CNT = N_EVC + 1;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CYC  = 2'd1,
        REG_EV0  = 2'd2,
        REG_EV1  = 2'd3
    } reg_idx_e;

    typedef enum logic [1:0] {
        M_STOP_FULL = 2'b00,
        M_STOP_DIV  = 2'b01,
        M_RUN_FULL  = 2'b10,
        M_RUN_DIV   = 2'b11
    } mode_e;

endpackage

// File: rtl/pmu_mode_fsm.sv
module pmu_mode_fsm
    import pmu_pkg::*;
#(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic en_in,
    input  logic div_in,
    input  logic presc_clr,
    output logic run,
    output logic div,
    output logic cyc_tick
);

    mode_e state_q, state_d;
    logic [DIV_LOG2-1:0] presc_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (load) begin
            unique case ({en_in, div_in})
                2'b00: state_d = M_STOP_FULL;
                2'b01: state_d = M_STOP_DIV;
                2'b10: state_d = M_RUN_FULL;
                2'b11: state_d = M_RUN_DIV;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_STOP_FULL;
        else        state_q <= state_d;
    end

    // prescaler only runs in divided counting mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            presc_q <= '0;
        else if (state_q != M_RUN_DIV || presc_clr)
            presc_q <= '0;
        else
            presc_q <= presc_q + 1'b1;
    end

    // outputs per state
    always_comb begin
        run      = 1'b0;
        div      = 1'b0;
        cyc_tick = 1'b0;
        unique case (state_q)
            M_STOP_FULL: ;
            M_STOP_DIV:  div = 1'b1;
            M_RUN_FULL: begin
                run      = 1'b1;
                cyc_tick = 1'b1;
            end
            M_RUN_DIV: begin
                run      = 1'b1;
                div      = 1'b1;
                cyc_tick = (presc_q == {DIV_LOG2{1'b1}});
            end
        endcase
    end

endmodule

// File: rtl/pmu_evsel.sv
module pmu_evsel
    import pmu_pkg::*;
#(
    parameter int NUM_EVT = 23
) (
    input  logic [SEL_W-1:0]   code,
    input  logic [NUM_EVT-1:0] pulses,
    output logic               hit
);

    // codes outside the implemented range (0xFF included) select nothing
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (code == SEL_W'(i)) hit = pulses[i];
        end
    end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);

    // clear beats load beats increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (clr) value <= '0;
        else if (wr)  value <= wdata;
        else if (inc) value <= value + 1'b1;
    end

    assign wrap = inc && !clr && !wr && (value == {W{1'b1}});

endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
    import pmu_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_EVT  = 23,
    parameter int DIV_LOG2 = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         reg_sel,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);

    logic                          ctrl_wr;
    logic                          cyc_rst, ev_rst;
    logic                          run, div, cyc_tick;
    logic [N_CNT-1:0]              ie_q, flag_q, flag_clr;
    logic [N_CNT-1:0]              clr_vec, wr_vec, inc_vec, wrap_vec;
    logic [N_EVC-1:0][SEL_W-1:0]   sel_q;
    logic [N_EVC-1:0]              hit;
    logic [N_CNT-1:0][CNT_W-1:0]   cnt_q;
    logic [REG_W-1:0]              ctrl_word;
    logic                          unused_bits;

    assign ctrl_wr = reg_wr && (reg_sel == REG_CTRL);
    assign cyc_rst = ctrl_wr && reg_wdata[CTL_CYRST];
    assign ev_rst  = ctrl_wr && reg_wdata[CTL_EVRST];
    assign unused_bits = ^{reg_wdata[31:28], reg_wdata[11], reg_wdata[7]};

    pmu_mode_fsm #(.DIV_LOG2(DIV_LOG2)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctrl_wr),
        .en_in    (reg_wdata[CTL_EN]),
        .div_in   (reg_wdata[CTL_DIV]),
        .presc_clr(cyc_rst),
        .run      (run),
        .div      (div),
        .cyc_tick (cyc_tick)
    );

    // interrupt enables and event codes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q  <= '0;
            sel_q <= {N_EVC{CODE_NONE}};
        end else if (ctrl_wr) begin
            ie_q     <= {reg_wdata[CTL_IE_EV1], reg_wdata[CTL_IE_EV0], reg_wdata[CTL_IE_CYC]};
            sel_q[0] <= reg_wdata[CTL_SEL0_LO +: SEL_W];
            sel_q[1] <= reg_wdata[CTL_SEL1_LO +: SEL_W];
        end
    end

    // overflow flags: a new wrap beats a clearing write
    assign flag_clr = ctrl_wr ? {reg_wdata[CTL_OF_EV1], reg_wdata[CTL_OF_EV0], reg_wdata[CTL_OF_CYC]}
                              : '0;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | wrap_vec;
    end

    // event selection
    for (genvar j = 0; j < N_EVC; j++) begin : g_sel
        pmu_evsel #(.NUM_EVT(NUM_EVT)) u_sel (
            .code  (sel_q[j]),
            .pulses(evt_in),
            .hit   (hit[j])
        );
        assign inc_vec[j+1] = run && hit[j];
        assign clr_vec[j+1] = ev_rst;
    end
    assign inc_vec[0] = cyc_tick;
    assign clr_vec[0] = cyc_rst;

    // counter bank
    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        assign wr_vec[k] = reg_wr && (reg_sel == 2'(k + 1));
        pmu_counter #(.W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr_vec[k]),
            .wr   (wr_vec[k]),
            .wdata(reg_wdata[CNT_W-1:0]),
            .inc  (inc_vec[k]),
            .value(cnt_q[k]),
            .wrap (wrap_vec[k])
        );
    end

    // packed control word view
    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTL_EN]                 = run;
        ctrl_word[CTL_DIV]                = div;
        ctrl_word[CTL_IE_EV0]             = ie_q[1];
        ctrl_word[CTL_IE_EV1]             = ie_q[2];
        ctrl_word[CTL_IE_CYC]             = ie_q[0];
        ctrl_word[CTL_OF_EV0]             = flag_q[1];
        ctrl_word[CTL_OF_EV1]             = flag_q[2];
        ctrl_word[CTL_OF_CYC]             = flag_q[0];
        ctrl_word[CTL_SEL0_LO +: SEL_W]   = sel_q[0];
        ctrl_word[CTL_SEL1_LO +: SEL_W]   = sel_q[1];
    end

    always_comb begin
        unique case (reg_sel)
            REG_CTRL: reg_rdata = ctrl_word;
            REG_CYC:  reg_rdata = REG_W'(cnt_q[0]);
            REG_EV0:  reg_rdata = REG_W'(cnt_q[1]);
            REG_EV1:  reg_rdata = REG_W'(cnt_q[2]);
        endcase
    end

    assign irq = |(flag_q & ie_q);

endmodule

// File: rtl/perf_monitor_checks.sv
module perf_monitor_checks #(
    parameter int CW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_sel,
    input logic              reg_wr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              irq,
    input logic              run,
    input logic [2:0]        flag_q,
    input logic [2:0][CW-1:0] cnt_q
);

    AST_HALT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reg_wr) |=> $stable(cnt_q)); // R2

    AST_EVRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && reg_wdata[1]) |=> (cnt_q[1] == '0 && cnt_q[2] == '0)); // R5

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1) |=> (cnt_q[0] == $past(reg_wdata[CW-1:0]))); // R6

    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[1] == {CW{1'b1}} && !reg_wr) |=> (cnt_q[1] != '0 || flag_q[1])); // R7

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_sel == 2'd0)) |=> irq); // R9

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd0) |-> ((reg_rdata & 32'hF000_0886) == 32'h0)); // R10

endmodule

bind perf_monitor perf_monitor_checks #(.CW(CNT_W)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_sel  (reg_sel),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .run      (run),
    .flag_q   (flag_q),
    .cnt_q    (cnt_q)
);

// File: tb/perf_monitor_bench.sv
module perf_monitor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [22:0] evt_in = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit          m_en, m_div;
    bit [2:0]    m_ie;   // ev0, ev1, cyc at bits 4,5,6
    bit [2:0]    m_of;   // ev0, ev1, cyc at bits 8,9,10
    bit [7:0]    m_s0, m_s1;
    bit [31:0]   m_cyc, m_e0, m_e1;
    int          m_presc;

    always #10 clk = ~clk;

    perf_monitor u_perf_monitor (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_sel  (reg_sel),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .evt_in   (evt_in),
        .irq      (irq)
    );

    function automatic bit [31:0] m_read(input bit [1:0] s);
        case (s)
            2'd0: return {4'b0, m_s1, m_s0, 1'b0, m_of, 1'b0, m_ie, m_div, 2'b00, m_en};
            2'd1: return m_cyc;
            2'd2: return m_e0;
            default: return m_e1;
        endcase
    endfunction

    task automatic check(input string tag, input bit [31:0] got, input bit [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic step(input bit [1:0] s, input bit w, input bit [31:0] d, input bit [22:0] e);
        bit cw, tick, h0, h1;
        bit [2:0] wr_of, clr;
        bit [31:0] n_cyc, n_e0, n_e1;
        int n_presc;
        reg_sel = s; reg_wr = w; reg_wdata = d; evt_in = e;
        cw = w && s == 2'd0;
        tick = m_en && (!m_div || m_presc == 63);
        h0 = 0; h1 = 0;
        if (m_en && m_s0 < 23) h0 = e[m_s0];
        if (m_en && m_s1 < 23) h1 = e[m_s1];
        wr_of = 3'b000;
        n_cyc = m_cyc; n_e0 = m_e0; n_e1 = m_e1;
        if (cw && d[2]) n_cyc = 0;
        else if (w && s == 2'd1) n_cyc = d;
        else if (tick) begin
            if (m_cyc == 32'hFFFF_FFFF) wr_of[2] = 1;
            n_cyc = m_cyc + 1;
        end
        if (cw && d[1]) n_e0 = 0;
        else if (w && s == 2'd2) n_e0 = d;
        else if (h0) begin
            if (m_e0 == 32'hFFFF_FFFF) wr_of[0] = 1;
            n_e0 = m_e0 + 1;
        end
        if (cw && d[1]) n_e1 = 0;
        else if (w && s == 2'd3) n_e1 = d;
        else if (h1) begin
            if (m_e1 == 32'hFFFF_FFFF) wr_of[1] = 1;
            n_e1 = m_e1 + 1;
        end
        n_presc = (!(m_en && m_div) || (cw && d[2])) ? 0 : (m_presc + 1) % 64;
        clr = cw ? d[10:8] : 3'b000;
        @(negedge clk);
        m_cyc = n_cyc; m_e0 = n_e0; m_e1 = n_e1; m_presc = n_presc;
        m_of = (m_of & ~clr) | wr_of;
        if (cw) begin
            m_en = d[0]; m_div = d[3]; m_ie = d[6:4];
            m_s0 = d[19:12]; m_s1 = d[27:20];
        end
        check("R6/R9 model read", reg_rdata, m_read(s));
        check("R9 model irq", {31'b0, irq}, {31'b0, |(m_of & m_ie)});
    endtask

    task automatic rd(input bit [1:0] s);
        step(s, 1'b0, 32'h0, '0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_en = 0; m_div = 0; m_ie = 0; m_of = 0;
        m_s0 = 8'hFF; m_s1 = 8'hFF;
        m_cyc = 0; m_e0 = 0; m_e1 = 0; m_presc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0); check("R1 ctrl", reg_rdata, 32'h0FFF_F000);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(2'd1); check("R1 cycle", reg_rdata, 32'h0);

        // R2 disabled: codes set, pulses present, nothing counts
        step(2'd0, 1'b1, 32'h0050_0000, '0);
        for (int i = 0; i < 5; i++) step(2'd2, 1'b0, 0, '1);
        check("R2 ev0 halted", reg_rdata, 32'h0);
        rd(2'd1); check("R2 cycle halted", reg_rdata, 32'h0);

        // R3 full-rate cycle counting
        step(2'd0, 1'b1, 32'h0050_0001, '0);
        for (int i = 0; i < 10; i++) rd(2'd1);
        check("R3 cycle full rate", reg_rdata, 32'd10);

        // R4 event selection
        for (int i = 0; i < 3; i++) step(2'd2, 1'b0, 0, 23'h000001);
        for (int i = 0; i < 2; i++) step(2'd2, 1'b0, 0, 23'h000020);
        for (int i = 0; i < 4; i++) step(2'd2, 1'b0, 0, 23'h000002);
        rd(2'd2); check("R4 ev0 count", reg_rdata, 32'd3);
        rd(2'd3); check("R4 ev1 count", reg_rdata, 32'd2);
        step(2'd0, 1'b1, 32'h017F_F001, '0);
        for (int i = 0; i < 4; i++) step(2'd2, 1'b0, 0, '1);
        check("R4 code 0xFF ignored", reg_rdata, 32'd3);
        rd(2'd3); check("R4 code 0x17 ignored", reg_rdata, 32'd2);

        // R5 resets win over increments, bits self clear
        step(2'd0, 1'b1, 32'h0050_0007, 23'h000001);
        rd(2'd1); check("R5 cycle reset then +1", reg_rdata, 32'd1);
        rd(2'd2); check("R5 ev0 reset beat pulse", reg_rdata, 32'd0);
        rd(2'd0); check("R5 reset bits read 0", reg_rdata, 32'h0050_0001);

        // R6 counter writes win over increments
        step(2'd1, 1'b1, 32'h1234_0000, '0);
        rd(2'd1); check("R6 cycle load", reg_rdata, 32'h1234_0001);
        step(2'd3, 1'b1, 32'd7, 23'h000020);
        rd(2'd3); check("R6 ev1 load beat pulse", reg_rdata, 32'd7);

        // R7 wrap sets flag, R9 irq with enable
        step(2'd0, 1'b1, 32'h0050_0011, '0);
        step(2'd2, 1'b1, 32'hFFFF_FFFE, '0);
        step(2'd2, 1'b0, 0, 23'h000001);
        step(2'd2, 1'b0, 0, 23'h000001);
        check("R7 ev0 wrapped", reg_rdata, 32'h0);
        rd(2'd0); check("R7 ev0 flag", reg_rdata, 32'h0050_0111);
        check("R9 irq raised", {31'b0, irq}, 32'h1);

        // R8 write-one-to-clear
        step(2'd0, 1'b1, 32'h0050_0011, '0);
        rd(2'd0); check("R8 zero leaves flag", reg_rdata, 32'h0050_0111);
        step(2'd0, 1'b1, 32'h0050_0111, '0);
        rd(2'd0); check("R8 one clears flag", reg_rdata, 32'h0050_0011);
        check("R8 irq dropped", {31'b0, irq}, 32'h0);
        step(2'd2, 1'b1, 32'hFFFF_FFFF, '0);
        step(2'd0, 1'b1, 32'h0050_0111, 23'h000001);
        rd(2'd0); check("R8 wrap beats clear", reg_rdata, 32'h0050_0111);
        check("R8 irq kept", {31'b0, irq}, 32'h1);
        step(2'd0, 1'b1, 32'h0050_0101, '0);

        // R9 enable gates interrupt for cycle counter
        step(2'd1, 1'b1, 32'hFFFF_FFFE, '0);
        rd(2'd1); rd(2'd1);
        rd(2'd0); check("R9 cycle flag set", reg_rdata, 32'h0050_0401);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        step(2'd0, 1'b1, 32'h0050_0041, '0);
        check("R9 irq on enable", {31'b0, irq}, 32'h1);
        step(2'd0, 1'b1, 32'h0050_0441, '0);
        rd(2'd0); check("R9 cleared", reg_rdata, 32'h0050_0041);

        // R10 reserved bits
        step(2'd0, 1'b1, 32'hFFFF_FFFF, '0);
        rd(2'd0); check("R10 reserved zero", reg_rdata, 32'h0FFF_F079);

        // R3 divided mode
        step(2'd0, 1'b1, 32'h0FFF_F07D, '0);
        for (int i = 0; i < 63; i++) rd(2'd1);
        check("R3 divided before 64", reg_rdata, 32'd0);
        rd(2'd1); check("R3 divided at 64", reg_rdata, 32'd1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule